// File: doc/BRIEF.md
# Low-Power Alarm and Wake Controller

This block decides when the chip's global clocks may stop and when they must come back. Software programs a 40-bit alarm reload value and then writes the start register. The controller drops its global clock-enable request and raises a status pin. The down-counter then runs on ticks taken from a slow low-power clock until it reaches zero or an interrupt arrives. The controller then asks for the clocks again. It keeps the status pin high until the clock source reports that it is stable.

A 64-bit real-time counter runs directly on the low-power clock and does not stop while the system clock is gated. The system domain never reads the counter while it is changing. Software requests a capture or a load, and a toggle handshake carries the request across the clock domains. The captured snapshot stays still until the next request. The same 40-bit counter can instead act as a watchdog. In that mode the clocks stay on and expiry raises a one-cycle reset request.

Register map: addresses 0 and 1 hold the RTC snapshot (read) or the RTC load value (write), low word first. Addresses 2 and 3 hold the live count (read) or the alarm reload value (write), low word first. Address 4 bit 0 is the watchdog-mode bit. A write to address 5 is a start, and a read of address 5 returns status {bit2 busy, bit1 refused, bit0 low-power}. A write to address 6 issues an RTC command: bit 1 loads, otherwise bit 0 captures. A write to address 7 with bit 0 set clears the refused flag.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, clk_en is 1, lp_status is 0, wd_rst is 0, the status register reads 0 and the count at address 2 reads 0.
- R2: The RTC advances once per lp_clk rising edge, also while clk_en is low. Two captures (address 6 bit 0) issued at the same lp_clk phase, k periods apart, give snapshots that differ by exactly k. Status bit 2 is 1 until the snapshot is ready.
- R3: A load command (address 6 bit 1) with staged value V, followed k lp_clk periods later at the same phase by a capture, gives a snapshot of V+k-1 across both words of the 64-bit value.
- R4: In alarm mode (address 4 bit 0 = 0), with irq_pending low, a start write with reload N sets clk_en to 0 and lp_status to 1. clk_en returns to 1 after exactly N further lp_clk rising edges. N = 0 wakes without waiting for an edge.
- R5: While gated, irq_pending high sets clk_en to 1 at the next clock edge, ahead of alarm expiry.
- R6: After a wake, lp_status stays 1 while clk_stable is 0. It falls one cycle after clk_stable is sampled at 1.
- R7: A start write in alarm mode while irq_pending is high is ignored: clk_en stays 1 and the count is unchanged. Status bit 1 is set and stays set until address 7 bit 0 is written.
- R8: In watchdog mode a start write loads N and keeps clk_en at 1. After exactly N lp_clk rising edges, wd_rst pulses high for one cycle. The count then rests at 0 with no further pulse.
- R9: A repeated start write in watchdog mode reloads the count, so expiry falls N edges after the latest start.
- R10: The live count is readable at addresses 2 and 3, including its upper 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Always-on system clock |
| lp_clk | input | 1 | Slow low-power clock, at most sys_clk/8 |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| clk_stable | input | 1 | Global clocks are stable again |
| clk_en | output | 1 | Global clock enable request |
| lp_status | output | 1 | High while in or leaving low power |
| wd_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume three things about the inputs. lp_clk is at least eight times slower than sys_clk, so every slow edge is seen as exactly one tick. irq_pending is a level that is already synchronous to sys_clk. clk_stable matters only while the block waits in its wake phase. The bench gives lp_clk a period of ten system cycles. It drives irq_pending and clk_stable on falling edges. It issues every timed start or RTC command at a fixed phase after a slow edge, so edge counts measured at the ports are exact.

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl #(
  parameter int RTC_W = 64,
  parameter int ALM_W = 40,
  parameter int DW    = 32
) (
  input  logic          sys_clk,
  input  logic          lp_clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_pending,
  input  logic          clk_stable,
  output logic          clk_en,
  output logic          lp_status,
  output logic          wd_rst
);

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} st_t;
  st_t st;

  logic [RTC_W-1:0] rtc, snap, rtc_ld;
  logic [ALM_W-1:0] alm_ld, alm_cnt;
  logic [2:0] req_lp, lps;
  logic [1:0] ack_s;
  logic ack_t, req_t, cmd_load, wd_en, wd_run, refused;

  // slow-clock domain: real-time counter and handshake receiver
  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) begin
      rtc    <= '0;
      snap   <= '0;
      req_lp <= '0;
      ack_t  <= 1'b0;
    end else begin
      req_lp <= {req_lp[1:0], req_t};
      if (req_lp[2] != req_lp[1]) begin
        ack_t <= req_lp[1];
        if (cmd_load) rtc <= rtc_ld;
        else begin
          snap <= rtc;
          rtc  <= rtc + 1'b1;
        end
      end else begin
        rtc <= rtc + 1'b1;
      end
    end
  end

  // system domain
  wire tick      = lps[1] & ~lps[2];
  wire busy      = req_t ^ ack_s[1];
  wire running   = (st == ST_RUN);
  wire start_wr  = bus_wr && bus_addr == 3'd5 && running;
  wire sleep_go  = start_wr && !wd_en && !irq_pending;
  wire refuse    = start_wr && !wd_en && irq_pending;
  wire wd_go     = start_wr && wd_en;
  wire mode_wr   = bus_wr && bus_addr == 3'd4 && running;
  wire cnt_zero  = (alm_cnt == '0);
  wire counting  = (st == ST_SLEEP) || wd_run;

  assign clk_en    = (st != ST_SLEEP);
  assign lp_status = !running;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      lps   <= '0;
      ack_s <= '0;
    end else begin
      lps   <= {lps[1:0], lp_clk};
      ack_s <= {ack_s[0], ack_t};
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t    <= 1'b0;
      cmd_load <= 1'b0;
      rtc_ld   <= '0;
    end else if (bus_wr && !busy) begin
      if (bus_addr == 3'd0) rtc_ld[DW-1:0] <= bus_wdata;
      if (bus_addr == 3'd1) rtc_ld[RTC_W-1:DW] <= bus_wdata[RTC_W-DW-1:0];
      if (bus_addr == 3'd6 && bus_wdata[1:0] != 2'b00) begin
        req_t    <= ~req_t;
        cmd_load <= bus_wdata[1];
      end
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_ld  <= '0;
      alm_cnt <= '0;
      wd_en   <= 1'b0;
      wd_run  <= 1'b0;
      wd_rst  <= 1'b0;
      refused <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 3'd2) alm_ld[DW-1:0] <= bus_wdata;
      if (bus_wr && bus_addr == 3'd3) alm_ld[ALM_W-1:DW] <= bus_wdata[ALM_W-DW-1:0];
      if (mode_wr) wd_en <= bus_wdata[0];

      if (sleep_go || wd_go) alm_cnt <= alm_ld;
      else if (counting && tick && !cnt_zero) alm_cnt <= alm_cnt - 1'b1;

      wd_rst <= wd_run && cnt_zero && !wd_go;
      if (wd_go) wd_run <= 1'b1;
      else if (mode_wr || cnt_zero) wd_run <= 1'b0;

      if (refuse) refused <= 1'b1;
      else if (bus_wr && bus_addr == 3'd7 && bus_wdata[0]) refused <= 1'b0;
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RUN;
    else begin
      case (st)
        ST_RUN:   if (sleep_go) st <= ST_SLEEP;
        ST_SLEEP: if (irq_pending || cnt_zero) st <= ST_WAKE;
        ST_WAKE:  if (clk_stable) st <= ST_RUN;
        default:  st <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = snap[DW-1:0];
      3'd1:    bus_rdata = DW'(snap[RTC_W-1:DW]);
      3'd2:    bus_rdata = alm_cnt[DW-1:0];
      3'd3:    bus_rdata = DW'(alm_cnt[ALM_W-1:DW]);
      3'd4:    bus_rdata = DW'(wd_en);
      3'd5:    bus_rdata = DW'({busy, refused, lp_status});
      default: bus_rdata = '0;
    endcase
  end

  // R4
  sleep_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!clk_en && !irq_pending && !cnt_zero) |=> !clk_en);

  // R4
  count_down_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd5) |=> alm_cnt <= $past(alm_cnt));

  // R6
  stable_exit_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(lp_status) |-> $past(clk_stable));

  // R7
  refuse_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5 && !lp_status && !wd_en && irq_pending) |=> (clk_en && refused));

  // R8
  wd_pulse_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);

  // R8
  wd_no_gate_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wd_en |-> clk_en);

endmodule

// File: tb/sim_lp_wake_ctrl.sv
module sim_lp_wake_ctrl;
  logic sys_clk = 1'b0, lp_clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, irq_pending = 1'b0, clk_stable = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic clk_en, lp_status, wd_rst;
  int total = 0, bad = 0;
  int lp_edges = 0, wd_pulses = 0, wd_edge = 0;
  logic saw_gate = 1'b0;

  lp_wake_ctrl u0 (.sys_clk(sys_clk), .lp_clk(lp_clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .clk_stable(clk_stable), .clk_en(clk_en),
    .lp_status(lp_status), .wd_rst(wd_rst));

  always #5 sys_clk = ~sys_clk;
  initial begin #3; forever #50 lp_clk = ~lp_clk; end
  always @(posedge lp_clk) lp_edges = lp_edges + 1;
  always @(negedge sys_clk) begin
    if (wd_rst) begin wd_pulses = wd_pulses + 1; wd_edge = lp_edges; end
    if (!clk_en) saw_gate = 1'b1;
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge sys_clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge sys_clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge sys_clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic align(input int target);
    wait (lp_edges >= target);
    repeat (4) @(negedge sys_clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin rd(3'd5, s); if (!s[2]) break; end
  endtask

  task automatic capture_at(input int target, output logic [63:0] v);
    logic [31:0] lo, hi, s;
    align(target);
    wr(3'd6, 32'h1);
    rd(3'd5, s);
    chk("R2 busy after capture request", s[2], 1'b1);
    wait_idle();
    rd(3'd0, lo); rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wait_wake(output int edges, input int e0);
    edges = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge sys_clk);
      if (clk_en) begin edges = lp_edges - e0; break; end
    end
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s, c0;
    logic [63:0] v1, v2;
    int e0, ed, p0;
    repeat (3) @(negedge sys_clk);
    rst_n = 1'b1;
    @(negedge sys_clk);
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 lp_status", lp_status, 1'b0);
    chk("R1 wd_rst", wd_rst, 1'b0);
    rd(3'd5, s); chk("R1 status", s, 0);
    rd(3'd2, s); chk("R1 count", s, 0);

    // R3: load 0x1_FFFFFFFE, capture 10 periods later
    wr(3'd0, 32'hFFFF_FFFE); wr(3'd1, 32'h1);
    e0 = lp_edges + 2;
    align(e0); wr(3'd6, 32'h2); wait_idle();
    capture_at(e0 + 10, v1);
    chk("R3 loaded snapshot", v1, 64'h1_FFFF_FFFE + 9);

    // R4: alarm sweep, N = 0..6
    for (int n = 0; n <= 6; n++) begin
      wr(3'd2, n); wr(3'd3, 0);
      align(lp_edges + 1);
      wr(3'd5, 0);
      e0 = lp_edges;
      chk("R4 clk_en low after start", clk_en, 1'b0);
      chk("R4 lp_status high after start", lp_status, 1'b1);
      wait_wake(ed, e0);
      chk("R4 wake edge count", ed, n);
      chk("R6 status still high at wake", lp_status, 1'b1);
      @(negedge sys_clk);
      chk("R6 status low after stable", lp_status, 1'b0);
    end

    // R2: RTC runs through a gated interval, exact difference
    e0 = lp_edges + 2;
    capture_at(e0, v1);
    wr(3'd2, 12); wr(3'd3, 0);
    align(e0 + 6); wr(3'd5, 0);
    wait_wake(ed, e0);
    chk("R2 gated interval happened", ed > 0, 1'b1);
    capture_at(e0 + 40, v2);
    chk("R2 rtc difference across sleep", v2 - v1, 40);

    // R5/R6: interrupt wake with delayed clock stability
    wr(3'd2, 30); wr(3'd3, 0);
    align(lp_edges + 1); wr(3'd5, 0);
    e0 = lp_edges;
    clk_stable = 1'b0;
    wait (lp_edges >= e0 + 5);
    @(negedge sys_clk); irq_pending = 1'b1;
    @(negedge sys_clk);
    chk("R5 clk_en after irq", clk_en, 1'b1);
    chk("R5 woke before alarm", lp_edges - e0 < 30, 1'b1);
    repeat (3) @(negedge sys_clk);
    chk("R6 status held without stable", lp_status, 1'b1);
    clk_stable = 1'b1;
    @(negedge sys_clk);
    chk("R6 status drops after stable", lp_status, 1'b0);

    // R7: start refused while interrupt pending
    wr(3'd2, 7);
    rd(3'd2, c0);
    wr(3'd5, 0);
    chk("R7 clk_en stays high", clk_en, 1'b1);
    chk("R7 no gating seen", lp_status, 1'b0);
    rd(3'd2, s); chk("R7 count unchanged", s, c0);
    rd(3'd5, s); chk("R7 refused flag", s[1:0], 2'b10);
    irq_pending = 1'b0;
    repeat (3) @(negedge sys_clk);
    rd(3'd5, s); chk("R7 flag sticky", s[1], 1'b1);
    wr(3'd7, 1);
    rd(3'd5, s); chk("R7 flag cleared", s[1], 1'b0);

    // R10: upper bits of live count
    wr(3'd4, 1);
    wr(3'd2, 5); wr(3'd3, 32'h12);
    wr(3'd5, 0);
    rd(3'd3, s); chk("R10 count high byte", s, 32'h12);
    rd(3'd2, s); chk("R10 count low word", s <= 5, 1'b1);
    wr(3'd4, 0); wr(3'd4, 1);

    // R8: watchdog sweep, N = 0..4
    for (int n = 0; n <= 4; n++) begin
      wr(3'd2, n); wr(3'd3, 0);
      align(lp_edges + 1);
      saw_gate = 1'b0; p0 = wd_pulses;
      wr(3'd5, 0);
      e0 = lp_edges;
      for (int i = 0; i < 3000 && wd_pulses == p0; i++) @(negedge sys_clk);
      chk("R8 expiry edge count", wd_edge - e0, n);
      wait (lp_edges >= e0 + n + 3);
      @(negedge sys_clk);
      chk("R8 single pulse", wd_pulses - p0, 1);
      chk("R8 clocks never gated", saw_gate, 1'b0);
      rd(3'd2, s); chk("R8 count rests at zero", s, 0);
    end

    // R9: restart reloads
    wr(3'd2, 6); wr(3'd3, 0);
    align(lp_edges + 1);
    p0 = wd_pulses;
    wr(3'd5, 0);
    e0 = lp_edges;
    align(e0 + 4); wr(3'd5, 0);
    chk("R9 no pulse before reload expiry", wd_pulses, p0);
    for (int i = 0; i < 3000 && wd_pulses == p0; i++) @(negedge sys_clk);
    chk("R9 expiry after reload", wd_edge - e0, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule